// File: doc/BRIEF.md
# Dependency-Gated Uniform-Unit Dispatcher

This block holds decoded instructions in a small in-order window and hands them to a pool of identical execution units. Every unit can run every operation, so the dispatcher never looks at the opcode. It only asks whether a unit is free. The compiler attaches one flag to each instruction that says it relies on earlier results. Unflagged instructions are treated as independent of everything before them. The hardware does not compare operands and never searches for parallelism.

On each cycle the dispatcher walks the window from the oldest entry. It takes as many instructions as the free units, the issue cap and the dependency rule allow, and stops at the first instruction that cannot go. The k-th instruction taken is bound to the k-th free unit, counted from unit index zero upward. A unit stays reserved from the issue until it raises its done bit, so long multi-cycle non-pipelined work simply holds the unit. A flagged instruction waits until it is the oldest entry and every unit is idle, which means every older instruction has completed.

Top module: `uniform_dispatch`

## Requirements
- R1: No more than ISSUE_MAX instructions (default 8) issue in one cycle, even when more units are free and more entries are waiting.
- R2: The instructions issued in a cycle are the oldest k entries of the window, in order. The i-th oldest goes to the i-th lowest-index free unit, and its op value appears unchanged on that unit's slice issue_op_o[u*OP_W +: OP_W].
- R3: An unflagged instruction (in_dep_i = 0) issues in the first cycle in which all older entries issue or have issued and a free unit is left for it, whatever its op value.
- R4: A flagged instruction (in_dep_i = 1) issues only when it is the oldest entry in the window and no unit is busy. Every younger entry waits behind it.
- R5: A unit is busy from the edge after its issue until the edge after its done_i bit is high. No instruction issues to a busy unit, and the unit can take a new instruction in the cycle after its done pulse.
- R6: in_ready_o is low exactly when the window holds WIN_DEPTH entries. An in_valid_i pulse while in_ready_o is low is dropped and does not enter the window.
- R7: After reset the window is empty, all units are idle, in_ready_o is high and issue_valid_o is zero.
- R8: One instruction per cycle is accepted while in_ready_o is high. It can issue from the cycle after acceptance. Each accepted instruction issues exactly once, and nothing issues from an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered to the window |
| in_op_i | input | OP_W | Opaque operation word |
| in_dep_i | input | 1 | 1 = depends on all older instructions |
| in_ready_o | output | 1 | Window has room |
| issue_valid_o | output | NUM_UNITS | Per-unit issue strobe |
| issue_op_o | output | NUM_UNITS*OP_W | Per-unit operation word, unit u at bits u*OP_W +: OP_W |
| done_i | input | NUM_UNITS | Per-unit completion pulse |

## Verification
The bench builds the block with NUM_UNITS = 10, WIN_DEPTH = 12 and ISSUE_MAX = 8. Ten units outnumber the issue cap, so the cap becomes the limiting term whenever all units free up together in front of a full window. The window, at more than eight deep, can hold a backlog past the cap while every unit is busy. A reference model advances a window and unit state of its own each cycle and predicts every strobe and op slice. The stimulus runs through equalised long latencies, a hand-built dependency mix and a long swept pattern of flags and latencies, which covers stalls caused by units, the cap, flags and an empty window.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned DEF_ISSUE_MAX = 8;

  typedef enum logic {
    UNIT_IDLE = 1'b0,
    UNIT_BUSY = 1'b1
  } unit_state_e;
endpackage

// File: rtl/insn_window.sv
module insn_window #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OP_W  = 8,
  parameter int unsigned PEEK  = 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned TAKE_W = $clog2(PEEK + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [OP_W-1:0]                op_i,
  input  logic                           dep_i,
  input  logic [TAKE_W-1:0]              pop_cnt_i,
  output logic [CNT_W-1:0]               count_o,
  output logic [PEEK-1:0][OP_W-1:0]      peek_op_o,
  output logic [PEEK-1:0]                peek_dep_o
);
  logic [DEPTH-1:0][OP_W-1:0] op_q;
  logic [DEPTH-1:0]           dep_q;
  logic [IDX_W-1:0]           head_q, tail_q;
  logic [CNT_W-1:0]           count_q;

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                input int unsigned step);
    int unsigned s;
    s = int'(base) + step;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      dep_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) begin
        op_q[tail_q]  <= op_i;
        dep_q[tail_q] <= dep_i;
        tail_q        <= wrap_add(tail_q, 1);
      end
      head_q  <= wrap_add(head_q, int'(pop_cnt_i));
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_cnt_i);
    end
  end

  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    logic [IDX_W-1:0] idx;
    assign idx           = wrap_add(head_q, i);
    assign peek_op_o[i]  = op_q[idx];
    assign peek_dep_o[i] = dep_q[idx];
  end

  assign count_o = count_q;
endmodule

// File: rtl/issue_select.sv
module issue_select #(
  parameter int unsigned PEEK      = 8,
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned CNT_W     = 5,
  localparam int unsigned FREE_W = $clog2(NUM_UNITS + 1),
  localparam int unsigned TAKE_W = $clog2(PEEK + 1)
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PEEK-1:0]   dep_i,
  input  logic [FREE_W-1:0] free_cnt_i,
  input  logic              all_idle_i,
  output logic [PEEK-1:0]   take_o,
  output logic [TAKE_W-1:0] take_cnt_o
);
  // Stops at the first entry that cannot go; nothing passes a held entry.
  always_comb begin
    logic go;
    go         = 1'b1;
    take_o     = '0;
    take_cnt_o = '0;
    for (int i = 0; i < PEEK; i++) begin
      logic ok;
      ok = go && (i < int'(count_i)) && (i < int'(free_cnt_i)) &&
           (!dep_i[i] || (i == 0 && all_idle_i));
      take_o[i] = ok;
      go        = ok;
      if (ok) take_cnt_o = take_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/unit_binder.sv
module unit_binder
  import disp_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned PEEK      = 8,
  parameter int unsigned OP_W      = 8,
  localparam int unsigned FREE_W = $clog2(NUM_UNITS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [PEEK-1:0]                take_i,
  input  logic [PEEK-1:0][OP_W-1:0]      op_i,
  input  logic [NUM_UNITS-1:0]           done_i,
  output logic [NUM_UNITS-1:0]           issue_valid_o,
  output logic [NUM_UNITS-1:0][OP_W-1:0] issue_op_o,
  output logic [FREE_W-1:0]              free_cnt_o,
  output logic                           all_idle_o
);
  unit_state_e [NUM_UNITS-1:0] state_q;
  logic        [NUM_UNITS-1:0] free;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign free[u] = (state_q[u] == UNIT_IDLE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               state_q[u] <= UNIT_IDLE;
      else if (issue_valid_o[u]) state_q[u] <= UNIT_BUSY;
      else if (done_i[u])        state_q[u] <= UNIT_IDLE;
    end
  end

  // k-th free unit (from index 0) receives the k-th taken slot.
  always_comb begin
    int rank;
    rank          = 0;
    issue_valid_o = '0;
    issue_op_o    = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (free[u]) begin
        if (rank < PEEK) begin
          issue_valid_o[u] = take_i[rank];
          issue_op_o[u]    = take_i[rank] ? op_i[rank] : '0;
        end
        rank = rank + 1;
      end
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) free_cnt_o = free_cnt_o + FREE_W'(free[u]);
  end

  assign all_idle_o = &free;
endmodule

// File: rtl/uniform_dispatch.sv
module uniform_dispatch
  import disp_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned WIN_DEPTH = 16,
  parameter int unsigned ISSUE_MAX = DEF_ISSUE_MAX,
  parameter int unsigned OP_W      = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [OP_W-1:0]             in_op_i,
  input  logic                        in_dep_i,
  output logic                        in_ready_o,
  output logic [NUM_UNITS-1:0]        issue_valid_o,
  output logic [NUM_UNITS*OP_W-1:0]   issue_op_o,
  input  logic [NUM_UNITS-1:0]        done_i
);
  localparam int unsigned CNT_W  = $clog2(WIN_DEPTH + 1);
  localparam int unsigned FREE_W = $clog2(NUM_UNITS + 1);
  localparam int unsigned TAKE_W = $clog2(ISSUE_MAX + 1);

  logic [CNT_W-1:0]                count;
  logic [ISSUE_MAX-1:0][OP_W-1:0]  peek_op;
  logic [ISSUE_MAX-1:0]            peek_dep;
  logic [ISSUE_MAX-1:0]            take;
  logic [TAKE_W-1:0]               take_cnt;
  logic [FREE_W-1:0]               free_cnt;
  logic                            all_idle;
  logic                            push;
  logic [NUM_UNITS-1:0][OP_W-1:0]  unit_op;

  assign in_ready_o = (count < CNT_W'(WIN_DEPTH));
  assign push       = in_valid_i && in_ready_o;

  insn_window #(
    .DEPTH (WIN_DEPTH),
    .OP_W  (OP_W),
    .PEEK  (ISSUE_MAX)
  ) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .op_i       (in_op_i),
    .dep_i      (in_dep_i),
    .pop_cnt_i  (take_cnt),
    .count_o    (count),
    .peek_op_o  (peek_op),
    .peek_dep_o (peek_dep)
  );

  issue_select #(
    .PEEK      (ISSUE_MAX),
    .NUM_UNITS (NUM_UNITS),
    .CNT_W     (CNT_W)
  ) u_select (
    .count_i    (count),
    .dep_i      (peek_dep),
    .free_cnt_i (free_cnt),
    .all_idle_i (all_idle),
    .take_o     (take),
    .take_cnt_o (take_cnt)
  );

  unit_binder #(
    .NUM_UNITS (NUM_UNITS),
    .PEEK      (ISSUE_MAX),
    .OP_W      (OP_W)
  ) u_binder (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .op_i          (peek_op),
    .done_i        (done_i),
    .issue_valid_o (issue_valid_o),
    .issue_op_o    (unit_op),
    .free_cnt_o    (free_cnt),
    .all_idle_o    (all_idle)
  );

  assign issue_op_o = unit_op;
endmodule

// File: rtl/uniform_dispatch_chk.sv
module uniform_dispatch_chk #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned WIN_DEPTH = 16,
  parameter int unsigned ISSUE_MAX = 8,
  parameter int unsigned OP_W      = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic [NUM_UNITS-1:0] issue_valid_o,
  input logic [NUM_UNITS-1:0] done_i
);
  localparam int unsigned CNT_W = $clog2(WIN_DEPTH + 1);

  logic [NUM_UNITS-1:0] busy_sh;
  logic [CNT_W-1:0]     cnt_sh;
  logic                 gap_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_sh <= '0;
      cnt_sh  <= '0;
    end else begin
      busy_sh <= (busy_sh & ~done_i) | issue_valid_o;
      cnt_sh  <= cnt_sh + CNT_W'(in_valid_i && in_ready_o) - CNT_W'($countones(issue_valid_o));
    end
  end

  always_comb begin
    logic skipped;
    skipped = 1'b0;
    gap_err = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!busy_sh[u]) begin
        if (issue_valid_o[u] && skipped) gap_err = 1'b1;
        if (!issue_valid_o[u]) skipped = 1'b1;
      end
    end
  end

  p_issue_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(issue_valid_o) <= ISSUE_MAX);

  p_lowest_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gap_err);

  p_no_busy_issue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o & busy_sh) == '0);

  p_done_from_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i & ~busy_sh) == '0);

  p_ready_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == (cnt_sh < CNT_W'(WIN_DEPTH)));

  p_empty_no_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_sh == '0) |-> (issue_valid_o == '0));
endmodule

bind uniform_dispatch uniform_dispatch_chk #(
  .NUM_UNITS (NUM_UNITS),
  .WIN_DEPTH (WIN_DEPTH),
  .ISSUE_MAX (ISSUE_MAX),
  .OP_W      (OP_W)
) u_chk (.*);

// File: tb/tb_uniform_dispatch.sv
`timescale 1ns/1ps
module tb_uniform_dispatch;
  localparam int NU = 10;
  localparam int WD = 12;
  localparam int IM = 8;
  localparam int OW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [OW-1:0]     in_op = '0;
  logic              in_dep = 1'b0;
  logic              in_ready;
  logic [NU-1:0]     issue_valid;
  logic [NU*OW-1:0]  issue_op;
  logic [NU-1:0]     done = '0;

  always #2.5 clk = ~clk;

  uniform_dispatch #(.NUM_UNITS(NU), .WIN_DEPTH(WD), .ISSUE_MAX(IM), .OP_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_op_i(in_op),
    .in_dep_i(in_dep), .in_ready_o(in_ready), .issue_valid_o(issue_valid),
    .issue_op_o(issue_op), .done_i(done));

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int dep_tab[256];
  int lat_tab[256];
  int m_q[$];
  bit m_busy[NU];
  int timer[NU];
  int accepted = 0;
  int issued = 0;
  int max_burst = 0;
  int dep_issued = 0;
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: predict, compare, then advance to the next edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int free_idx[$];
      int k;
      int nbusy;
      string tag;
      logic [NU-1:0] exp_v;
      nbusy = 0;
      free_idx.delete();
      for (int u = 0; u < NU; u++) begin
        if (m_busy[u]) nbusy++;
        else free_idx.push_back(u);
      end
      k = 0;
      tag = "R3";
      for (int i = 0; i < IM; i++) begin
        if (i >= m_q.size()) begin tag = (k == 0) ? "R8" : "R3"; break; end
        if (i >= free_idx.size()) begin tag = "R5"; break; end
        if (dep_tab[m_q[i]] != 0 && !(i == 0 && nbusy == 0)) begin tag = "R4"; break; end
        k++;
        if (k == IM) tag = "R1";
      end
      exp_v = '0;
      for (int j = 0; j < k; j++) exp_v[free_idx[j]] = 1'b1;
      chk(issue_valid == exp_v, tag, int'(issue_valid), int'(exp_v));
      chk(in_ready == (m_q.size() < WD), "R6", int'(in_ready), int'(m_q.size() < WD));
      for (int j = 0; j < k; j++) begin
        int u;
        u = free_idx[j];
        chk(issue_op[u*OW +: OW] == OW'(m_q[j]), "R2", int'(issue_op[u*OW +: OW]), m_q[j]);
      end
      if (k > max_burst) max_burst = k;
      if (k > 0 && dep_tab[m_q[0]] != 0) dep_issued++;
      for (int u = 0; u < NU; u++) if (done[u]) m_busy[u] = 0;
      for (int j = 0; j < k; j++) begin
        m_busy[free_idx[j]] = 1;
        timer[free_idx[j]]  = lat_tab[m_q[0]];
        void'(m_q.pop_front());
        issued++;
      end
      if (in_valid && m_q.size() + k - k < WD + 0 && in_ready) begin
        m_q.push_back(int'(in_op));
        accepted++;
      end
    end
  end

  // Unit emulation: done pulse lat cycles after the issue cycle.
  initial begin
    forever begin
      @(posedge clk); #1;
      for (int u = 0; u < NU; u++) begin
        done[u] = 1'b0;
        if (timer[u] > 0) begin
          timer[u]--;
          if (timer[u] == 0) done[u] = 1'b1;
        end
      end
    end
  end

  task automatic push(input bit dep, input int lat);
    int id;
    id = seq & 255;
    seq++;
    dep_tab[id] = dep;
    lat_tab[id] = lat;
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1'b1; in_op = OW'(id); in_dep = dep;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    bit idle;
    idle = 0;
    while (!idle) begin
      @(posedge clk); #1;
      idle = (m_q.size() == 0);
      for (int u = 0; u < NU; u++) if (m_busy[u] || timer[u] != 0) idle = 0;
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin m_busy[u] = 0; timer[u] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
    chk(issue_valid == '0, "R7", int'(issue_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(issue_valid == '0, "R7", int'(issue_valid), 0);

    // Occupy all units with latencies that end together, then back up the window.
    for (int i = 0; i < NU; i++) push(0, 60 - i);
    for (int i = 0; i < WD; i++) push(0, 3);
    @(negedge clk);
    chk(in_ready == 1'b0, "R6", int'(in_ready), 0);
    @(posedge clk); #1;
    // Offer while full: must be dropped.
    dep_tab[200] = 0; lat_tab[200] = 1;
    in_valid = 1'b1; in_op = OW'(200); in_dep = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_idle();
    chk(max_burst == IM, "R1", max_burst, IM);

    // Dependency mix behind busy units.
    seq = 0;
    for (int i = 0; i < NU; i++) push(0, 20 - i);
    push(0, 2); push(1, 5); push(0, 1); push(0, 4);
    push(1, 1); push(1, 2); push(0, 3); push(0, 1);
    wait_idle();
    chk(dep_issued >= 3, "R4", dep_issued, 3);

    // Swept flags and latencies.
    for (int n = 0; n < 400; n++) push((n * 7) % 5 == 0, 1 + (n * 13) % 7);
    wait_idle();
    chk(issued == accepted, "R8", issued, accepted);
    chk(accepted == 2 * NU + WD + 8 + 400, "R6", accepted, 2 * NU + WD + 8 + 400);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule